// File: doc/BRIEF.md
# Multiplexed Local Bus Cycle Controller

This block runs the external bus cycles of a 16-bit embedded processor core. An internal requester offers one transfer at a time: a 20-bit physical address, a read/write flag, write data and a three-bit cycle-type code. The controller runs each transfer as a multiplexed bus cycle. The low address bits and the data share one 16-bit lane group. The upper address bits and the cycle-type code go out on their own pins. The controller also generates the address latch pulse, separate read and write strobes, and the enable and direction controls for external bus transceivers.

A cycle takes at least four clocks, named T1, T2, T3 and T4. Two ready inputs can stretch it. The synchronous ready is used as it arrives. The asynchronous ready first passes through a flop synchronizer. When the bus is between cycles, an external master may take it over with a hold request. The controller answers with an acknowledge and releases every pin it drives.

The pins are modelled as value outputs plus output enables, so the chip-level pad ring can build the tristate drivers.

Top module: `lbus_cycle_ctrl`

## Requirements
- R1: During and after reset, with no request and hold low, the controller is idle. In that state `hlda`=0, `ctl_oe`=1, `ad_oe`=0, `ale`=0, `rd_n`=`wr_n`=`den_n`=1, `dt_r`=1, `bus_status`=3'b111 (passive) and `rd_valid`=0.
- R2: `req_ack` is 1 in a clock where `req_valid`=1, `hold`=0 and the controller is idle, in T4, or in the release clock after a hold. The request is latched at that clock's end, and the next clock is T1.
- R3: In T1, `ale`=1, `ad_oe`=1 and `ad_out` carries address bits 15:0, while `addr_hi` carries bits 19:16 through T4. `bus_status` shows the request's code from T1 through T3 and any wait states, and reads 3'b111 at all other times.
- R4: In a read, `ad_oe`=0 from T2 through T4, `rd_n`=0 in T2, T3 and wait states, and `dt_r`=0 from T1 through T4. `rd_data` takes `ad_in` at the end of the clock in which ready is found, and `rd_valid`=1 in T4.
- R5: In a write, `ad_out` carries the write data with `ad_oe`=1 from T2 through T4, `wr_n`=0 in T2, T3 and wait states, and `dt_r`=1.
- R6: `den_n`=0 only during the data phase: T2, T3 and wait states for a read, and T2 through T4 for a write. It is 1 in T1 and between cycles.
- R7: Ready (`srdy` OR the synchronized `ardy`) is sampled at the end of T3 and of each wait state. When ready is 0, one wait state follows. When ready is 1, T4 follows. No cycle is shorter than four clocks.
- R8: `ardy` passes through two flops. A level sampled at clock edge k takes part in the ready decision at edge k+2, and `srdy` takes part at the same edge it is sampled.
- R9: Hold is granted only from idle, T4 or the release clock. `hlda` goes to 1 on the next clock, and hold wins over a request made in the same clock.
- R10: While `hlda`=1, `ctl_oe`=0 and `ad_oe`=0. This releases the address, data, status, strobe and transceiver pins.
- R11: After `hold` drops, `hlda` goes to 0 for one release clock with the pins still released. From the next clock the controller drives again: T1 if a request was accepted in the release clock, idle otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Internal transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Physical address |
| req_wdata | input | 16 | Write data |
| req_status | input | 3 | Cycle-type code shown on the status pins |
| req_ack | output | 1 | Request accepted at this clock's end |
| rd_data | output | 16 | Captured read data |
| rd_valid | output | 1 | Read data valid (T4 of a read) |
| ad_out | output | 16 | Multiplexed address/data value |
| ad_in | input | 16 | Multiplexed lanes as seen at the pins |
| ad_oe | output | 1 | Enable for the multiplexed lanes |
| addr_hi | output | 4 | Upper address bits 19:16 |
| bus_status | output | 3 | Cycle-type status |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| ctl_oe | output | 1 | Enable for address-high, status, strobe and transceiver pins |
| srdy | input | 1 | Synchronous ready |
| ardy | input | 1 | Asynchronous ready |
| hold | input | 1 | Bus request from an external master |
| hlda | output | 1 | Bus grant to the external master |

## Verification
At a cycle boundary, a hold request and a new internal request can arrive in the same clock. The bench provokes this in three ways: it raises both together while idle, it raises hold during a running cycle so that it meets the end of T4, and it keeps a request waiting across a whole hold period. A behavioural model computes which of the two wins, when `hlda` rises and falls, and how long the release clock lasts before T1. The pins are compared with that model on every clock. Ready arrival via the synchronizer is run in the same way against the wait-state count.

// File: rtl/lbus_pkg.sv
package lbus_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_T3   = 3'd3,
      ST_TW   = 3'd4,
      ST_T4   = 3'd5,
      ST_HOLD = 3'd6,
      ST_HREL = 3'd7
   } lbus_state_e;

   // states in which a new cycle or a hold grant may begin
   function automatic logic at_boundary(lbus_state_e s);
      return (s == ST_IDLE) || (s == ST_T4) || (s == ST_HREL);
   endfunction

   // T2, T3 and wait states: strobe window
   function automatic logic in_strobe(lbus_state_e s);
      return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
   endfunction

   function automatic logic in_cycle(lbus_state_e s);
      return (s == ST_T1) || in_strobe(s) || (s == ST_T4);
   endfunction
endpackage

// File: rtl/lbus_rdy_sync.sv
module lbus_rdy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lbus_rdy_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic q;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= g_stage[i-1].q;
         end
      end
   end

   assign sync_out = g_stage[STAGES-1].q;
endmodule

// File: rtl/lbus_seq.sv
module lbus_seq
   import lbus_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   parameter int STAT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [STAT_W-1:0] req_status,
   input  logic              hold,
   input  logic              srdy,
   input  logic              ardy_sync,
   input  logic [DATA_W-1:0] ad_in,
   output lbus_state_e       state,
   output logic              cur_write,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [DATA_W-1:0] cur_wdata,
   output logic [STAT_W-1:0] cur_status,
   output logic [DATA_W-1:0] rd_data,
   output logic              req_ack
);
   lbus_state_e state_nx;
   logic        ready;
   logic        boundary;
   logic        sample_pt;

   assign ready     = srdy | ardy_sync;
   assign boundary  = at_boundary(state);
   assign sample_pt = (state == ST_T3) || (state == ST_TW);
   assign req_ack   = boundary && !hold && req_valid;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE, ST_T4, ST_HREL: begin
            if (hold)           state_nx = ST_HOLD;
            else if (req_valid) state_nx = ST_T1;
            else                state_nx = ST_IDLE;
         end
         ST_T1:   state_nx = ST_T2;
         ST_T2:   state_nx = ST_T3;
         ST_T3,
         ST_TW:   state_nx = ready ? ST_T4 : ST_TW;
         ST_HOLD: state_nx = hold ? ST_HOLD : ST_HREL;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cur_write  <= 1'b0;
         cur_addr   <= '0;
         cur_wdata  <= '0;
         cur_status <= '1;
         rd_data    <= '0;
      end else begin
         state <= state_nx;
         if (req_ack) begin
            cur_write  <= req_write;
            cur_addr   <= req_addr;
            cur_wdata  <= req_wdata;
            cur_status <= req_status;
         end
         if (sample_pt && ready && !cur_write) rd_data <= ad_in;
      end
   end

   AST_MIN_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T4) |-> ($past(state) == ST_T3 || $past(state) == ST_TW)); // R7
   AST_WAIT_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_pt && !ready) |=> (state == ST_TW)); // R7
   AST_HOLD_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (!boundary && state != ST_HOLD) |=> (state != ST_HOLD)); // R9
   AST_HOLD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && hold) |-> !req_ack); // R9
   AST_ACK_TO_T1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> (state == ST_T1)); // R2
endmodule

// File: rtl/lbus_pin_drv.sv
module lbus_pin_drv
   import lbus_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   parameter int STAT_W = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  lbus_state_e              state,
   input  logic                     cur_write,
   input  logic [ADDR_W-1:0]        cur_addr,
   input  logic [DATA_W-1:0]        cur_wdata,
   input  logic [STAT_W-1:0]        cur_status,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     ad_oe,
   output logic [ADDR_W-DATA_W-1:0] addr_hi,
   output logic [STAT_W-1:0]        bus_status,
   output logic                     ale,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic                     den_n,
   output logic                     dt_r,
   output logic                     ctl_oe,
   output logic                     hlda,
   output logic                     rd_valid
);
   localparam logic [STAT_W-1:0] PASSIVE = '1;

   logic cyc, strobe, t1, t4;

   assign cyc    = in_cycle(state);
   assign strobe = in_strobe(state);
   assign t1     = (state == ST_T1);
   assign t4     = (state == ST_T4);

   assign hlda   = (state == ST_HOLD);
   assign ctl_oe = !((state == ST_HOLD) || (state == ST_HREL));

   assign ale    = t1;
   assign ad_oe  = t1 || (cur_write && (strobe || t4));
   assign ad_out = t1 ? cur_addr[DATA_W-1:0] : cur_wdata;
   assign addr_hi    = cur_addr[ADDR_W-1:DATA_W];
   assign bus_status = (t1 || strobe) ? cur_status : PASSIVE;

   assign rd_n  = !(strobe && !cur_write);
   assign wr_n  = !(strobe && cur_write);
   assign den_n = !(strobe || (t4 && cur_write));
   assign dt_r  = cyc ? cur_write : 1'b1;
   assign rd_valid = t4 && !cur_write;

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_oe |-> (rd_n || wr_n)); // R4
   AST_READ_LANES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && ctl_oe) |-> !ad_oe); // R4
   AST_ALE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (ad_oe && den_n)); // R3
   AST_HLDA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      hlda |-> (!ad_oe && !ctl_oe)); // R10
   AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hlda) |-> (!ctl_oe && !ad_oe)); // R11
endmodule

// File: rtl/lbus_cycle_ctrl.sv
module lbus_cycle_ctrl
   import lbus_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int DATA_W      = 16,
   parameter int STAT_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   input  logic [STAT_W-1:0]        req_status,
   output logic                     req_ack,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     rd_valid,
   output logic [DATA_W-1:0]        ad_out,
   input  logic [DATA_W-1:0]        ad_in,
   output logic                     ad_oe,
   output logic [ADDR_W-DATA_W-1:0] addr_hi,
   output logic [STAT_W-1:0]        bus_status,
   output logic                     ale,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic                     den_n,
   output logic                     dt_r,
   output logic                     ctl_oe,
   input  logic                     srdy,
   input  logic                     ardy,
   input  logic                     hold,
   output logic                     hlda
);
   if (ADDR_W <= DATA_W) begin : g_bad_width
      $error("lbus_cycle_ctrl: ADDR_W must exceed DATA_W");
   end
   if (STAT_W < 1) begin : g_bad_status
      $error("lbus_cycle_ctrl: STAT_W must be at least 1");
   end

   lbus_state_e       state;
   logic              cur_write;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_wdata;
   logic [STAT_W-1:0] cur_status;
   logic              ardy_sync;

   lbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(ardy), .sync_out(ardy_sync)
   );

   lbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_status(req_status),
      .hold(hold), .srdy(srdy), .ardy_sync(ardy_sync), .ad_in(ad_in),
      .state(state), .cur_write(cur_write), .cur_addr(cur_addr),
      .cur_wdata(cur_wdata), .cur_status(cur_status),
      .rd_data(rd_data), .req_ack(req_ack)
   );

   lbus_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_drv (
      .clk(clk), .rst_n(rst_n), .state(state),
      .cur_write(cur_write), .cur_addr(cur_addr), .cur_wdata(cur_wdata),
      .cur_status(cur_status),
      .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi), .bus_status(bus_status),
      .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r),
      .ctl_oe(ctl_oe), .hlda(hlda), .rd_valid(rd_valid)
   );
endmodule

// File: tb/lbus_cycle_ctrl_test.sv
module lbus_cycle_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [2:0]  req_status = '0;
   logic [15:0] ad_in = 16'h0100;
   logic        srdy = 1'b0, ardy = 1'b0, hold = 1'b0;
   logic        req_ack, rd_valid, ad_oe, ale, rd_n, wr_n, den_n, dt_r, ctl_oe, hlda;
   logic [15:0] rd_data, ad_out;
   logic [3:0]  addr_hi;
   logic [2:0]  bus_status;

   always #5 clk = ~clk;

   lbus_cycle_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_status(req_status),
      .req_ack(req_ack), .rd_data(rd_data), .rd_valid(rd_valid),
      .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .addr_hi(addr_hi),
      .bus_status(bus_status), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
      .den_n(den_n), .dt_r(dt_r), .ctl_oe(ctl_oe), .srdy(srdy), .ardy(ardy),
      .hold(hold), .hlda(hlda)
   );

   int n_pass = 0, n_total = 0, cycles = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act === exp) n_pass++;
      else $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
   endtask

   // behavioural model: 0 idle,1 T1,2 T2,3 T3,4 Tw,5 T4,6 hold,7 release
   int          mst = 0;
   bit          m_wr = 0, a1 = 0, a2 = 0;
   logic [19:0] m_addr = '0;
   logic [15:0] m_wd = '0, m_rd = '0;
   logic [2:0]  m_st = 3'b111;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         mst = 0; a1 = 0; a2 = 0; m_rd = '0; m_wr = 0;
      end else begin
         bit rdy, bnd;
         rdy = srdy | a2;
         bnd = (mst == 0 || mst == 5 || mst == 7);
         if ((mst == 3 || mst == 4) && rdy && !m_wr) m_rd = ad_in;
         if (bnd) begin
            if (hold) mst = 6;
            else if (req_valid) begin
               mst = 1; m_wr = req_write; m_addr = req_addr;
               m_wd = req_wdata; m_st = req_status;
            end else mst = 0;
         end else if (mst == 1) mst = 2;
         else if (mst == 2) mst = 3;
         else if (mst == 3 || mst == 4) mst = rdy ? 5 : 4;
         else if (mst == 6) mst = hold ? 6 : 7;
         a2 = a1; a1 = ardy;
      end
      #2;
      if (!done) begin
         bit e_ctl, e_strobe, e_cyc;
         e_ctl    = !(mst == 6 || mst == 7);
         e_strobe = (mst >= 2 && mst <= 4);
         e_cyc    = (mst >= 1 && mst <= 5);
         chk("R9 hlda", hlda, mst == 6);
         chk("R10/R11 ctl_oe", ctl_oe, e_ctl);
         chk("R2 req_ack", req_ack,
             (mst == 0 || mst == 5 || mst == 7) && !hold && req_valid);
         chk("R3/R4/R5 ad_oe", ad_oe, (mst == 1) || (m_wr && (e_strobe || mst == 5)));
         if (mst == 1) chk("R3 ad_out address", ad_out, m_addr[15:0]);
         else if (m_wr && (e_strobe || mst == 5)) chk("R5 ad_out data", ad_out, m_wd);
         if (e_ctl) begin
            chk("R3 ale", ale, mst == 1);
            chk("R1/R3 bus_status", bus_status, (mst >= 1 && mst <= 4) ? m_st : 3'b111);
            chk("R4 rd_n", rd_n, !(e_strobe && !m_wr));
            chk("R5 wr_n", wr_n, !(e_strobe && m_wr));
            chk("R6 den_n", den_n, !(e_strobe || (mst == 5 && m_wr)));
            chk("R4/R5 dt_r", dt_r, e_cyc ? m_wr : 1'b1);
            if (e_cyc) chk("R3 addr_hi", addr_hi, m_addr[19:16]);
         end
         chk("R4 rd_valid", rd_valid, mst == 5 && !m_wr);
         if (mst == 5 && !m_wr) chk("R4/R7/R8 rd_data", rd_data, m_rd);
      end
   end

   // ready generator and bus lane data, driven away from the active edge
   int wait_req = 0, rdy_kind = 0, wcnt = 0;
   always @(negedge clk) begin
      bit rn;
      ad_in <= ad_in + 16'h1357;
      if (mst == 1) wcnt = wait_req;
      if (mst >= 2 && mst <= 4) begin
         rn = (wcnt == 0);
         if (wcnt > 0) wcnt--;
      end else rn = 0;
      srdy <= (rdy_kind == 0) ? rn : 1'b0;
      ardy <= (rdy_kind == 1) ? rn : 1'b0;
   end

   task automatic do_req(input bit w, input logic [19:0] a, input logic [15:0] d,
                         input logic [2:0] s);
      req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_status = s;
      forever begin
         @(posedge clk); #3;
         if (req_ack) break;
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      idle(3);
      rst_n = 1;                               // R1 checked every clock in idle
      idle(3);
      rdy_kind = 0; wait_req = 0;
      do_req(0, 20'hA1234, 16'h0000, 3'b101); idle(6);   // R4 read, no wait
      do_req(1, 20'h500FE, 16'hBEEF, 3'b110); idle(6);   // R5 write
      wait_req = 3;
      do_req(0, 20'h3C0DE, 16'h0, 3'b001); idle(9);      // R7 waits, sync ready
      rdy_kind = 1; wait_req = 0;
      do_req(0, 20'h7F00F, 16'h0, 3'b100); idle(8);      // R8 async ready
      wait_req = 2;
      do_req(1, 20'h9AAAA, 16'h1234, 3'b010); idle(9);   // R8 async write
      rdy_kind = 0; wait_req = 0;
      do_req(0, 20'h11111, 16'h0, 3'b000);               // back-to-back R2
      do_req(1, 20'h22222, 16'h5A5A, 3'b011); idle(6);
      hold = 1; idle(5); hold = 0; idle(4);              // R9/R10/R11 idle hold
      hold = 1; idle(2);                                 // request waits during hold
      fork
         do_req(0, 20'hC4321, 16'h0, 3'b101);
         begin idle(4); hold = 0; end
      join
      idle(6);
      wait_req = 2;
      do_req(1, 20'hD0F0F, 16'hCAFE, 3'b110);            // hold meets end of T4
      hold = 1; idle(9); hold = 0; idle(4);
      wait_req = 0;
      fork                                               // R9 hold wins same clock
         begin hold = 1; do_req(0, 20'hE7777, 16'h0, 3'b001); end
         begin idle(3); hold = 0; end
      join
      idle(8);
      done = 1;
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end

   always @(posedge clk) begin
      if (cycles > 20000 && !done) begin
         done = 1;
         n_total++;
         $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
         $display("%0d/%0d checks passed", n_pass, n_total);
         $finish;
      end
   end
endmodule